// File: doc/BRIEF.md
# Pin Edge Interrupt Capture Unit

This unit watches a bank of general-purpose input pins and turns chosen signal transitions into sticky pending bits. Every pin owns two arming bits, one for low-to-high and one for high-to-low transitions. Both may be armed together, and then either direction latches the pin's pending bit. Each pin is brought into the local clock domain through a chain of flops before its transitions are detected.

Software reaches the unit through a small 32-bit register port that takes an address, write and read strobes and data. It sets the two arming masks and reads the pending mask. To clear pending bits, software writes ones to them. The lowest eight pins each drive a dedicated level-high interrupt line. One further bank line stays high while any pending bit in the bank is set. A new edge that is captured while software clears the pending mask is never lost.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset both arming masks and the pending mask read as zero, every interrupt line is low and the read data is zero.
- R2: When a pin's rising arm bit is set, a low-to-high transition on that pin sets its pending bit on the third rising clock edge after the pin changes.
- R3: When a pin's falling arm bit is set, a high-to-low transition on that pin sets its pending bit with the same three-edge latency.
- R4: With both arm bits of a pin set, a transition in either direction sets the pin's pending bit.
- R5: A transition whose direction is not armed for that pin leaves the pending bit clear. A pin with both arm bits clear never becomes pending.
- R6: Writing the pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: If a pin's armed transition is captured on the same clock edge as a clear of that bit, the bit stays set.
- R8: Interrupt line irq_pin[i] (i = 0..7) equals pending bit i in every cycle.
- R9: irq_bank is high exactly when at least one of the 28 pending bits is set.
- R10: Register byte offsets are 0x0 for the rising arm mask, 0x4 for the falling arm mask and 0x8 for the pending mask. Bit i of each maps to pin i. Bits 31..28 read as zero. A read strobe returns data on the next rising edge. Any other offset reads zero.
- R11: Writing 0x0FFFFFFF to the pending register clears all pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gpio_in | input | 28 | Asynchronous pin levels |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one edge after the read strobe |
| irq_pin | output | 8 | Per-pin interrupt lines for pins 0..7 |
| irq_bank | output | 1 | Combined interrupt line for the bank |

## Verification
A pending bit shows up three rising edges after a pin changes: two synchroniser stages, then the pending register. The interrupt lines follow the pending bits in the same cycle. Read data appears on the edge that takes the read strobe, and a write takes effect on its strobe edge. The bench changes its inputs on the falling edge and steps a behavioural model on every rising edge, using a queue of past pin samples. It compares all outputs on the next falling edge. The directed reads wait for exactly these counts of edges, and the edge/clear collision is placed so that the edge and the clear land on the same rising edge.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
   localparam int unsigned OFS_RISE_ARM = 0;
   localparam int unsigned OFS_FALL_ARM = 4;
   localparam int unsigned OFS_PENDING  = 8;
   localparam int unsigned MIN_SYNC     = 2;
endpackage

// File: rtl/gpio_edge_detect.sv
`timescale 1ns/1ps
module gpio_edge_detect #(
   parameter int unsigned NUM_PINS    = 28,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] pins_raw,
   input  logic [NUM_PINS-1:0] arm_rise,
   input  logic [NUM_PINS-1:0] arm_fall,
   output logic [NUM_PINS-1:0] hit_mask
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < gpio_edge_pkg::MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain_q;
      logic                   last_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[TOP-1:0], pins_raw[p]};
            last_q  <= chain_q[TOP];
         end
      end

      assign hit_mask[p] = (arm_rise[p] &  chain_q[TOP] & ~last_q)
                         | (arm_fall[p] & ~chain_q[TOP] &  last_q);
   end

   // R5: nothing may register a hit on a pin with no direction armed
   assert_unarmed_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      ((hit_mask & ~(arm_rise | arm_fall)) == '0));
endmodule

// File: rtl/gpio_edge_status.sv
`timescale 1ns/1ps
module gpio_edge_status #(
   parameter int unsigned NUM_PINS = 28
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] hit_mask,
   input  logic [NUM_PINS-1:0] wipe_mask,
   output logic [NUM_PINS-1:0] pend_q
);
   always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= (pend_q & ~wipe_mask) | hit_mask;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (pend_q == '0));

   // R7: a captured hit always survives into the pending mask
   assert_hit_wins_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((pend_q & $past(hit_mask)) == $past(hit_mask)));

   // R6: wiped bits without a hit drop
   assert_wipe_clears_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((pend_q & $past(wipe_mask & ~hit_mask)) == '0));

   // R6: bits not wiped keep their value
   assert_keep_unwiped_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((pend_q & $past(pend_q & ~wipe_mask)) == $past(pend_q & ~wipe_mask)));
endmodule

// File: rtl/gpio_edge_regs.sv
`timescale 1ns/1ps
module gpio_edge_regs #(
   parameter int unsigned NUM_PINS = 28,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [NUM_PINS-1:0] pend_q,
   output logic [NUM_PINS-1:0] arm_rise,
   output logic [NUM_PINS-1:0] arm_fall,
   output logic [NUM_PINS-1:0] wipe_mask,
   output logic [DATA_W-1:0]   bus_rdata
);
   import gpio_edge_pkg::*;

   if (NUM_PINS >= DATA_W) begin : g_bad_width
      $error("NUM_PINS must be narrower than DATA_W");
   end

   localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE_ARM);
   localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL_ARM);
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);

   logic                sel_rise, sel_fall, sel_pend;
   logic [NUM_PINS-1:0] wr_bits;
   logic [NUM_PINS-1:0] rd_pick;
   logic [DATA_W-1:0]   rd_wide;
   logic                unused_hi;

   assign sel_rise  = (bus_addr == A_RISE);
   assign sel_fall  = (bus_addr == A_FALL);
   assign sel_pend  = (bus_addr == A_PEND);
   assign wr_bits   = bus_wdata[NUM_PINS-1:0];
   assign unused_hi = ^bus_wdata[DATA_W-1:NUM_PINS];
   assign wipe_mask = (bus_wr && sel_pend) ? wr_bits : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         arm_rise <= '0;
         arm_fall <= '0;
      end else if (bus_wr) begin
         if (sel_rise) arm_rise <= wr_bits;
         if (sel_fall) arm_fall <= wr_bits;
      end
   end

   always_comb begin
      if (sel_rise)      rd_pick = arm_rise;
      else if (sel_fall) rd_pick = arm_fall;
      else if (sel_pend) rd_pick = pend_q;
      else               rd_pick = '0;
      rd_wide                = '0;
      rd_wide[NUM_PINS-1:0]  = rd_pick;
   end

   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_wide;
   end

   // R10: upper data bits never carry anything
   assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (bus_rdata[DATA_W-1:NUM_PINS] == '0));
endmodule

// File: rtl/gpio_edge_irq_unit.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit #(
   parameter int unsigned NUM_PINS    = 28,
   parameter int unsigned NUM_DIRECT  = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_PINS-1:0]   gpio_in,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [NUM_DIRECT-1:0] irq_pin,
   output logic                  irq_bank
);
   if (NUM_DIRECT == 0 || NUM_DIRECT > NUM_PINS) begin : g_bad_direct
      $error("NUM_DIRECT must lie in 1..NUM_PINS");
   end

   logic [NUM_PINS-1:0] arm_rise, arm_fall, wipe_mask, hit_mask, pend_q;

   gpio_edge_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .pend_q(pend_q), .arm_rise(arm_rise), .arm_fall(arm_fall),
      .wipe_mask(wipe_mask), .bus_rdata(bus_rdata)
   );

   gpio_edge_detect #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk(clk), .rst(rst), .pins_raw(gpio_in), .arm_rise(arm_rise),
      .arm_fall(arm_fall), .hit_mask(hit_mask)
   );

   gpio_edge_status #(.NUM_PINS(NUM_PINS)) u_status (
      .clk(clk), .rst(rst), .hit_mask(hit_mask), .wipe_mask(wipe_mask), .pend_q(pend_q)
   );

   assign irq_pin  = pend_q[NUM_DIRECT-1:0];
   assign irq_bank = |pend_q;

   // R9: the bank line is high whenever a direct line is high
   assert_bank_covers_R9: assert property (@(posedge clk) disable iff (rst)
      (|irq_pin) |-> irq_bank);
endmodule

// File: tb/gpio_edge_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit_tb;
   localparam int NP = 28;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [27:0] gpio_in = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  irq_pin;
   logic        irq_bank;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #4 clk = ~clk;

   gpio_edge_irq_unit u_dut (
      .clk(clk), .rst(rst), .gpio_in(gpio_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pin(irq_pin), .irq_bank(irq_bank)
   );

   // behavioural reference
   logic [27:0] hist[$];
   logic [27:0] m_rise, m_fall, m_pend;
   logic [31:0] m_rdata;

   always @(posedge clk) begin
      if (rst) begin
         hist = '{28'h0, 28'h0, 28'h0};
         m_rise = '0; m_fall = '0; m_pend = '0; m_rdata = '0;
      end else begin
         logic [27:0] now_v, was_v, hits, wipe;
         now_v = hist[hist.size()-2];
         was_v = hist[hist.size()-3];
         hits  = (m_rise & now_v & ~was_v) | (m_fall & ~now_v & was_v);
         if (bus_rd) begin
            case (bus_addr)
               4'h0:    m_rdata = {4'h0, m_rise};
               4'h4:    m_rdata = {4'h0, m_fall};
               4'h8:    m_rdata = {4'h0, m_pend};
               default: m_rdata = '0;
            endcase
         end
         wipe = (bus_wr && bus_addr == 4'h8) ? bus_wdata[27:0] : '0;
         m_pend = (m_pend & ~wipe) | hits;
         if (bus_wr && bus_addr == 4'h0) m_rise = bus_wdata[27:0];
         if (bus_wr && bus_addr == 4'h4) m_fall = bus_wdata[27:0];
         hist.push_back(gpio_in);
         if (hist.size() > 3) void'(hist.pop_front());
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R8 model irq_pin", {24'h0, irq_pin}, {24'h0, m_pend[7:0]});
         chk("R9 model irq_bank", {31'h0, irq_bank}, {31'h0, |m_pend});
         chk("R10 model rdata", bus_rdata, m_rdata);
      end
   end

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst = 1'b0;
      // R1
      chk("R1 irq_pin", {24'h0, irq_pin}, 32'h0);
      chk("R1 irq_bank", {31'h0, irq_bank}, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);
      bus_read(4'h0, v); chk("R1 rise arm", v, 32'h0);
      bus_read(4'h4, v); chk("R1 fall arm", v, 32'h0);
      bus_read(4'h8, v); chk("R1 pending", v, 32'h0);
      // R10 map and width
      bus_write(4'h0, 32'hFFFF_FFFF);
      bus_read(4'h0, v); chk("R10 rise readback", v, 32'h0FFF_FFFF);
      bus_write(4'h4, 32'hA5A5_5A5A);
      bus_read(4'h4, v); chk("R10 fall readback", v, 32'h05A5_5A5A);
      bus_read(4'hC, v); chk("R10 unmapped", v, 32'h0);
      bus_write(4'h0, 32'h0); bus_write(4'h4, 32'h0);
      // R5 unarmed pin
      gpio_in[3] = 1'b1; idle(4); gpio_in[3] = 1'b0; idle(4);
      bus_read(4'h8, v); chk("R5 unarmed", v, 32'h0);
      // R2 rising
      bus_write(4'h0, 32'h0000_0401);
      gpio_in[0] = 1'b1; gpio_in[10] = 1'b1;
      idle(2);
      chk("R2 not yet", {24'h0, irq_pin}, 32'h0);
      idle(1);
      chk("R2 third edge", {24'h0, irq_pin}, 32'h1);
      bus_read(4'h8, v); chk("R2 pending", v, 32'h0000_0401);
      chk("R9 bank", {31'h0, irq_bank}, 32'h1);
      bus_write(4'h8, 32'h0000_0401);
      gpio_in[0] = 1'b0; gpio_in[10] = 1'b0; idle(5);
      bus_read(4'h8, v); chk("R5 fall unarmed", v, 32'h0);
      // R3 falling
      bus_write(4'h0, 32'h0);
      bus_write(4'h4, 32'h0010_0020);
      gpio_in[5] = 1'b1; gpio_in[20] = 1'b1; idle(5);
      bus_read(4'h8, v); chk("R3 rise ignored", v, 32'h0);
      gpio_in[5] = 1'b0; gpio_in[20] = 1'b0; idle(4);
      bus_read(4'h8, v); chk("R3 fall captured", v, 32'h0010_0020);
      // R6
      bus_write(4'h8, 32'h0000_0020);
      bus_read(4'h8, v); chk("R6 one bit wiped", v, 32'h0010_0000);
      bus_write(4'h8, 32'h0);
      bus_read(4'h8, v); chk("R6 zero write keeps", v, 32'h0010_0000);
      chk("R8 pin5 low", {31'h0, irq_pin[5]}, 32'h0);
      bus_write(4'h8, 32'h0010_0000);
      // R4 both directions
      bus_write(4'h4, 32'h0);
      bus_write(4'h0, 32'h0000_1080);
      bus_write(4'h4, 32'h0000_1080);
      gpio_in[12] = 1'b1; idle(4);
      bus_read(4'h8, v); chk("R4 rise", v, 32'h0000_1000);
      bus_write(4'h8, 32'h0000_1000);
      gpio_in[12] = 1'b0; idle(4);
      bus_read(4'h8, v); chk("R4 fall", v, 32'h0000_1000);
      bus_write(4'h8, 32'h0000_1000);
      // R7 collision on pin 7
      gpio_in[7] = 1'b1; idle(4);
      chk("R8 pin7 line", {24'h0, irq_pin}, 32'h80);
      bus_write(4'h8, 32'h80);
      chk("R6 pin7 wiped", {24'h0, irq_pin}, 32'h0);
      gpio_in[7] = 1'b0;
      idle(2);
      bus_write(4'h8, 32'h80);
      chk("R7 edge wins line", {24'h0, irq_pin}, 32'h80);
      bus_read(4'h8, v); chk("R7 edge wins pending", v, 32'h80);
      // R11 clear all
      gpio_in[12] = 1'b1; gpio_in[7] = 1'b1; idle(4);
      bus_read(4'h8, v); chk("R11 before", v, 32'h0000_1080);
      bus_write(4'h8, 32'h0FFF_FFFF);
      chk("R11 bank low", {31'h0, irq_bank}, 32'h0);
      bus_read(4'h8, v); chk("R11 pending zero", v, 32'h0);
      idle(3);
      finish_run();
   end
endmodule